// File: doc/BRIEF.md
# Reset Hold-Duration Meter

This block measures how long an active-low push-button reset line stays asserted. The button line is asynchronous and passes through a flop synchronizer. While the synchronized line is low, a counter advances once per cycle of the reference clock. At 25 MHz each count stands for 40 ns, and the default 29-bit counter spans about 21.4 seconds.

When the line is released the counter stops and keeps its value. Firmware can then read it through a single 32-bit status/control word. Firmware compares the value with its own threshold to tell a short press from a long "restore defaults" press. Firmware then writes a one to bit 31 to clear the counter.

The counter saturates at all-ones instead of wrapping. A fresh press starts a new measurement from zero, even if the previous value was never cleared.

Top module: `rst_hold_meter`

## Requirements
- R1: After power-on reset (porN low) the read word is zero.
- R2: A press that keeps the raw button line low across H consecutive rising clock edges reads back exactly H, once the synchronizer has drained.
- R3: The count stops at 2^CNT_W-1 and stays there however long the press lasts. A press of 2^CNT_W or more edges reads 2^CNT_W-1.
- R4: After release the value stays constant until it is cleared or a new press begins.
- R5: A register write whose bit 31 is 1 sets the count to zero on that clock edge.
- R6: A register write whose bit 31 is 0 leaves the count unchanged, whatever the other bits hold.
- R7: A new falling edge of the synchronized line restarts counting from zero. A second press of H2 edges reads H2, not the sum of both presses.
- R8: Read bits above the counter (bits 31 to CNT_W) are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (25 MHz nominal) |
| porN | input | 1 | Asynchronous power-on reset, active low |
| btnRstN | input | 1 | Asynchronous push-button reset line, active low |
| regWrEn | input | 1 | Write strobe for the status/control word |
| regWrData | input | 32 | Write data; bit 31 requests a clear |
| regRdData | output | 32 | Read data; counter in the low CNT_W bits |

## Verification
The bench sweeps press lengths of 1 to 40 edges and expects an exact count for each. A design that counted the synchronizer latency twice, or missed the first low cycle, would read off by one or two.

Presses just below, at and above the saturation point check that a counter which wrapped would read a small number. Back-to-back presses with no clear between them check that a design which accumulated would read the sum.

Writes with bit 31 clear but every other bit set check that a decode of the wrong bit would zero the count.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
  typedef struct packed {
    logic clear;
    logic restart;
    logic advance;
  } holdStrb_t;
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/rhm_ctrl.sv
module rhm_ctrl
  import rhm_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int CLR_BIT = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output holdStrb_t        strb
);
  logic prevLine;
  logic fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= 1'b1;
    else       prevLine <= lineN;
  end

  assign fallSeen = prevLine & ~lineN;

  always_comb begin
    strb         = '0;
    strb.clear   = wrEn & wrData[CLR_BIT];
    strb.restart = fallSeen;
    strb.advance = ~lineN & ~fallSeen;
  end

  // R7: a restart marks one edge only
  a_r7_single_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> !strb.restart);

  // R2: the load strobe and the increment strobe never fire together
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.restart, strb.advance}));
endmodule

// File: rtl/rhm_count.sv
module rhm_count
  import rhm_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rstN,
  input  holdStrb_t        strb,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic atMax;
  assign atMax = (cnt == MAX_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.clear)   cnt <= '0;
    else if (strb.restart) cnt <= ONE;
    else if (strb.advance && !atMax) cnt <= cnt + ONE;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !strb.clear && !strb.restart) |=> cnt == MAX_CNT);

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> cnt == '0);

  a_r7_restart_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.restart && !strb.clear) |=> cnt == ONE);

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.restart && !strb.advance) |=> $stable(cnt));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clear && !atMax) |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rhm_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter int REG_W       = 32,
  parameter int CLR_BIT     = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             btnRstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData
);
  localparam int PAD_W = REG_W - CNT_W;

  logic             lineSyncN;
  holdStrb_t        strb;
  logic [CNT_W-1:0] holdCnt;

  rhm_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (porN),
    .asyncIn(btnRstN),
    .syncOut(lineSyncN)
  );

  rhm_ctrl #(.REG_W(REG_W), .CLR_BIT(CLR_BIT)) ctrl_i (
    .clk   (clk),
    .rstN  (porN),
    .lineN (lineSyncN),
    .wrEn  (regWrEn),
    .wrData(regWrData),
    .strb  (strb)
  );

  rhm_count #(.CNT_W(CNT_W)) count_i (
    .clk (clk),
    .rstN(porN),
    .strb(strb),
    .cnt (holdCnt)
  );

  assign regRdData = {{PAD_W{1'b0}}, holdCnt};

  // R6: a write without the clear bit leaves the read word alone
  a_r6_plain_write: assert property (@(posedge clk) disable iff (!porN)
    (regWrEn && !regWrData[CLR_BIT] && lineSyncN) |=> $stable(regRdData));
endmodule

// File: tb/rst_hold_meter_tb.sv
module rst_hold_meter_tb_top;
  localparam int CLK_PERIOD = 40;
  localparam int CNT_W      = 10;
  localparam int REG_W      = 32;
  localparam int MAXV       = (1 << CNT_W) - 1;
  localparam int DRAIN      = 6;

  logic             clk = 1'b0;
  logic             porN = 1'b0;
  logic             btnRstN = 1'b1;
  logic             regWrEn = 1'b0;
  logic [REG_W-1:0] regWrData = '0;
  logic [REG_W-1:0] regRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_hold_meter #(.CNT_W(CNT_W)) dut_i (
    .clk      (clk),
    .porN     (porN),
    .btnRstN  (btnRstN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );

  task automatic check(string req, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic press(int edges);
    @(negedge clk) btnRstN = 1'b0;
    repeat (edges) @(negedge clk);
    btnRstN = 1'b1;
    repeat (DRAIN) @(negedge clk);
  endtask

  task automatic writeWord(logic [REG_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: read 0x%08h expected completion", regRdData);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", regRdData, 32'h0);
    porN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", regRdData, 32'h0);

    // R2, R7, R8: sweep of press lengths, no clear in between
    for (int h = 1; h <= 40; h++) begin
      press(h);
      check("R2", regRdData, REG_W'(h));
      check("R8", {regRdData[REG_W-1:CNT_W], {CNT_W{1'b0}}}, 32'h0);
      repeat (15) @(negedge clk);
      check("R4", regRdData, REG_W'(h));
    end

    // R6: write with every bit except 31 set
    writeWord(32'h7FFF_FFFF);
    @(negedge clk);
    check("R6", regRdData, 32'd40);
    writeWord(32'h0000_0000);
    check("R6", regRdData, 32'd40);

    // R5: clear through bit 31
    writeWord(32'h8000_0000);
    check("R5", regRdData, 32'h0);

    // R7: long press then short press reads the short one
    press(30);
    check("R7", regRdData, 32'd30);
    press(7);
    check("R7", regRdData, 32'd7);

    // R3: saturation boundary
    press(MAXV - 1);
    check("R3", regRdData, REG_W'(MAXV - 1));
    press(MAXV);
    check("R3", regRdData, REG_W'(MAXV));
    press(MAXV + 1);
    check("R3", regRdData, REG_W'(MAXV));
    press(MAXV + 200);
    check("R3", regRdData, REG_W'(MAXV));
    check("R8", {regRdData[REG_W-1:CNT_W], {CNT_W{1'b0}}}, 32'h0);
    repeat (50) @(negedge clk);
    check("R4", regRdData, REG_W'(MAXV));

    // threshold use: 100 counts per scaled "second", a 3-unit hold
    press(3 * 100);
    check("R2", regRdData, 32'd300);
    checks++;
    if (regRdData < 32'd300) begin
      fails++;
      $display("FAIL R2: read %0d expected at least 300", regRdData);
    end

    writeWord(32'hFFFF_FFFF);
    check("R5", regRdData, 32'h0);

    done = 1'b1;
    finishRun();
  end
endmodule